// File: doc/BRIEF.md
# Pixel Depth Conversion Lookup and Packer

This block converts pixel fields from one bit depth to another. A staging word supplies a field of `n` bits that starts at bit offset `o`, where offset 0 is the most significant bit of the word. The field is added to a table base and used as an address into an internal conversion table. The table entry found there is masked to the entry width that the current depth pair calls for, zero-extended to a full word, and written into one of two working registers, called D and S.

A packing stage then builds an output word in S out of converted fields held in D. It has two modes. The placed mode writes each field straight into its final position. The shift-accumulate mode shifts S left and appends D, so after the last field of a sequence the fields sit where the placed mode would have put them.

Depth codes 0 to 3 stand for 1, 2, 4 and 8 bits per pixel. Software loads the table through a write port, then sets the depth pair and the table base, and then issues lookups and packing steps from the surrounding engine.

Top module: `pixel_depth_conv`

## Requirements
- R1: While reset is held and on the cycle after it is released, `d_q`, `s_q`, `lk_valid` and `lk_err` are all zero.
- R2: A lookup reads the field `(lk_word >> (32 - (lk_off + lk_len))) & ((1 << lk_len) - 1)`, so offset 0 is bit 31. It reads table entry `(base + field) mod 256`. Entries are written through `tab_we`/`tab_addr`/`tab_data`. A read on the same edge as a write to the same address returns the old entry. Both `lk_len = 32` with `lk_off = 0`, and `lk_off = 31` with `lk_len = 1`, are legal.
- R3: A lookup request sampled at clock edge k updates its destination register at edge k+1, and raises `lk_valid` for exactly the one cycle after edge k+1. Requests may be issued on every cycle.
- R4: The entry width comes from the depth pair (src, dst), with codes 0, 1, 2, 3 meaning 1, 2, 4, 8 bits:
  - src > dst uses 1 byte.
  - src = dst uses 4 bytes.
  - 0→1, 1→2 and 2→3 use 2 bytes.
  - 0→2, 0→3 and 1→3 use 4 bytes.
  - The result is the entry masked to that width and zero-extended.
  - After reset the pair is (0,0) and the base is 0.
- R5: `lk_to_s = 0` sends the result to D and `lk_to_s = 1` sends it to S. The other register is not touched.
- R6: When `lk_len = 0` or `lk_off + lk_len > 32`, `lk_err` is raised together with `lk_valid`, and zero is written to the destination.
- R7: Placed packing (`asm_shift_mode = 0`) sets S = D << (32 - n) when o = 0, and S = S | (D << (32 - (o + n))) when o ≠ 0.
- R8: Shift-accumulate packing (`asm_shift_mode = 1`) sets S = D when o = 0, and S = (S << n) | D when o ≠ 0. A shift of 32 or more bits gives zero.
- R9: Placed packing with `asm_off + asm_len > 32` leaves S unchanged.
- R10: When a lookup writes S on the same edge as a packing step, the lookup result is the one kept.
- R11: Packing the fields at offsets 0, 8, 16, 24 (width 8) in placed mode gives the same S as packing the same fields in shift-accumulate mode.
- R12: A configuration write (`cfg_we`) takes effect for lookup requests sampled after its edge. A request on the same edge uses the previous entry width and base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tab_we | input | 1 | Table write strobe |
| tab_addr | input | 8 | Table write address |
| tab_data | input | 32 | Table write data |
| cfg_we | input | 1 | Load depth pair and base |
| cfg_src_depth | input | 2 | Source depth code |
| cfg_dst_depth | input | 2 | Destination depth code |
| cfg_base | input | 8 | Table base added to the field |
| lk_req | input | 1 | Lookup request |
| lk_word | input | 32 | Staging word holding the field |
| lk_off | input | 6 | Field offset from the most significant bit |
| lk_len | input | 6 | Field width in bits |
| lk_to_s | input | 1 | 1: result to S, 0: result to D |
| asm_req | input | 1 | Packing step request |
| asm_shift_mode | input | 1 | 0: placed, 1: shift-accumulate |
| asm_off | input | 6 | Packing offset |
| asm_len | input | 6 | Packing field width |
| d_q | output | 32 | Register D |
| s_q | output | 32 | Register S |
| lk_valid | output | 1 | Lookup result written this cycle |
| lk_err | output | 1 | Lookup field out of range |

## Verification
The bench uses the default 32-bit word and 8-bit table address. With these values all 256 entries can be filled with distinct full-width patterns, so every masking width shows up in the low bits. The 6-bit offset and length ports reach the error region above 32 as well as the exact boundaries at 32. All sixteen depth pairs are stepped through with a nonzero base so that address wraparound occurs, and a random phase overlaps table writes, configuration writes, lookups and packing steps on the same edges.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    parameter int unsigned WORD_W = 32;
    localparam int unsigned OW = $clog2(WORD_W) + 1;

    typedef enum logic [1:0] {
        ENT_1B = 2'd0,
        ENT_2B = 2'd1,
        ENT_4B = 2'd2
    } ent_size_e;

    typedef struct packed {
        logic      vld;
        logic      err;
        logic      to_s;
        ent_size_e size;
    } lk_stage_t;

    // Entry width chosen by the (source, destination) depth pair.
    function automatic ent_size_e size_for(input logic [1:0] src, input logic [1:0] dst);
        ent_size_e r;
        if (dst < src)
            r = ENT_1B;
        else if (dst == src)
            r = ENT_4B;
        else begin
            case (src)
                2'd0:    r = (dst == 2'd1) ? ENT_2B : ENT_4B;
                2'd1:    r = (dst == 2'd2) ? ENT_2B : ENT_4B;
                default: r = ENT_2B;
            endcase
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] size_mask(input ent_size_e s);
        logic [WORD_W-1:0] m;
        case (s)
            ENT_1B:  m = WORD_W'(32'h0000_00FF);
            ENT_2B:  m = WORD_W'(32'h0000_FFFF);
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pdc_table_ram.sv
module pdc_table_ram #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Read-first: a read colliding with a write returns the old entry.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
        if (we)
            mem[waddr] <= wdata;
    end
endmodule

// File: rtl/pdc_field_extract.sv
module pdc_field_extract
    import pdc_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic [WORD_W-1:0] word,
    input  logic [OW-1:0]     off,
    input  logic [OW-1:0]     len,
    output logic [IDX_W-1:0]  field,
    output logic              bad
);
    localparam logic [OW:0] W_L = OW'(WORD_W) + 1'b0;

    logic [OW:0]       sum;
    logic [OW:0]       shamt;
    logic [IDX_W-1:0]  idx_mask;

    always_comb begin
        sum      = {1'b0, off} + {1'b0, len};
        bad      = (len == '0) || (sum > W_L);
        shamt    = bad ? '0 : (W_L - sum);
        idx_mask = ~({IDX_W{1'b1}} << len);
        field    = IDX_W'(word >> shamt) & idx_mask;
    end
endmodule

// File: rtl/pdc_packer.sv
module pdc_packer
    import pdc_pkg::*;
(
    input  logic [WORD_W-1:0] s_cur,
    input  logic [WORD_W-1:0] d_cur,
    input  logic              shift_mode,
    input  logic [OW-1:0]     off,
    input  logic [OW-1:0]     len,
    output logic [WORD_W-1:0] s_next
);
    localparam logic [OW:0] W_L = OW'(WORD_W) + 1'b0;

    logic [OW:0] sum;
    logic        in_range;

    always_comb begin
        sum      = {1'b0, off} + {1'b0, len};
        in_range = (sum <= W_L);
        s_next   = s_cur;
        if (shift_mode) begin
            if (off == '0)
                s_next = d_cur;
            else
                s_next = (s_cur << len) | d_cur;
        end else if (in_range) begin
            if (off == '0)
                s_next = d_cur << (W_L - {1'b0, len});
            else
                s_next = s_cur | (d_cur << (W_L - sum));
        end
    end
endmodule

// File: rtl/pixel_depth_conv.sv
module pixel_depth_conv
    import pdc_pkg::*;
#(
    parameter int unsigned TAB_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tab_we,
    input  logic [TAB_AW-1:0] tab_addr,
    input  logic [WORD_W-1:0] tab_data,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_src_depth,
    input  logic [1:0]        cfg_dst_depth,
    input  logic [TAB_AW-1:0] cfg_base,
    input  logic              lk_req,
    input  logic [WORD_W-1:0] lk_word,
    input  logic [OW-1:0]     lk_off,
    input  logic [OW-1:0]     lk_len,
    input  logic              lk_to_s,
    input  logic              asm_req,
    input  logic              asm_shift_mode,
    input  logic [OW-1:0]     asm_off,
    input  logic [OW-1:0]     asm_len,
    output logic [WORD_W-1:0] d_q,
    output logic [WORD_W-1:0] s_q,
    output logic              lk_valid,
    output logic              lk_err
);
    localparam logic [OW:0] W_L = OW'(WORD_W) + 1'b0;

    ent_size_e         size_r;
    logic [TAB_AW-1:0] base_r;
    lk_stage_t         stg_q;
    logic [TAB_AW-1:0] field;
    logic              field_bad;
    logic [TAB_AW-1:0] rd_addr;
    logic [WORD_W-1:0] ram_q;
    logic [WORD_W-1:0] lk_result;
    logic [WORD_W-1:0] s_packed;

    always_ff @(posedge clk) begin
        if (rst) begin
            size_r <= size_for(2'd0, 2'd0);
            base_r <= '0;
        end else if (cfg_we) begin
            size_r <= size_for(cfg_src_depth, cfg_dst_depth);
            base_r <= cfg_base;
        end
    end

    pdc_field_extract #(.IDX_W(TAB_AW)) i_extract (
        .word  (lk_word),
        .off   (lk_off),
        .len   (lk_len),
        .field (field),
        .bad   (field_bad)
    );

    assign rd_addr = base_r + field;

    pdc_table_ram #(.AW(TAB_AW), .DW(WORD_W)) i_ram (
        .clk   (clk),
        .we    (tab_we),
        .waddr (tab_addr),
        .wdata (tab_data),
        .raddr (rd_addr),
        .rdata (ram_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '{vld: 1'b0, err: 1'b0, to_s: 1'b0, size: ENT_4B};
        end else begin
            stg_q.vld  <= lk_req;
            stg_q.err  <= field_bad;
            stg_q.to_s <= lk_to_s;
            stg_q.size <= size_r;
        end
    end

    assign lk_result = stg_q.err ? '0 : (ram_q & size_mask(stg_q.size));

    pdc_packer i_packer (
        .s_cur      (s_q),
        .d_cur      (d_q),
        .shift_mode (asm_shift_mode),
        .off        (asm_off),
        .len        (asm_len),
        .s_next     (s_packed)
    );

    // Lookup write-back to S takes precedence over a packing step.
    always_ff @(posedge clk) begin
        if (rst) begin
            d_q      <= '0;
            s_q      <= '0;
            lk_valid <= 1'b0;
            lk_err   <= 1'b0;
        end else begin
            lk_valid <= stg_q.vld;
            lk_err   <= stg_q.vld & stg_q.err;
            if (stg_q.vld && !stg_q.to_s)
                d_q <= lk_result;
            if (stg_q.vld && stg_q.to_s)
                s_q <= lk_result;
            else if (asm_req)
                s_q <= s_packed;
        end
    end

    AST_LK_LATENCY: assert property (@(posedge clk) disable iff (rst)
        lk_req |-> ##2 lk_valid);  // R3

    AST_ERR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (lk_req && ((lk_len == '0) || (({1'b0, lk_off} + {1'b0, lk_len}) > W_L))) |-> ##2 lk_err);  // R6

    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_err) |-> ((($past(stg_q.to_s)) ? s_q : d_q) == '0));  // R6

    AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_err && ($past(stg_q.size) == ENT_1B))
            |-> ((($past(stg_q.to_s)) ? s_q[WORD_W-1:8] : d_q[WORD_W-1:8]) == '0));  // R4

    AST_D_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(stg_q.vld && !stg_q.to_s) |=> $stable(d_q));  // R5

    AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        lk_err |-> lk_valid);  // R6

endmodule

// File: tb/test_pixel_depth_conv.sv
module test_pixel_depth_conv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tab_we = 1'b0;
    logic [7:0]  tab_addr = '0;
    logic [31:0] tab_data = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_src_depth = '0;
    logic [1:0]  cfg_dst_depth = '0;
    logic [7:0]  cfg_base = '0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_word = '0;
    logic [5:0]  lk_off = '0;
    logic [5:0]  lk_len = '0;
    logic        lk_to_s = 1'b0;
    logic        asm_req = 1'b0;
    logic        asm_shift_mode = 1'b0;
    logic [5:0]  asm_off = '0;
    logic [5:0]  asm_len = '0;
    logic [31:0] d_q, s_q;
    logic        lk_valid, lk_err;

    pixel_depth_conv i_pixel_depth_conv (
        .clk(clk), .rst(rst),
        .tab_we(tab_we), .tab_addr(tab_addr), .tab_data(tab_data),
        .cfg_we(cfg_we), .cfg_src_depth(cfg_src_depth), .cfg_dst_depth(cfg_dst_depth),
        .cfg_base(cfg_base),
        .lk_req(lk_req), .lk_word(lk_word), .lk_off(lk_off), .lk_len(lk_len),
        .lk_to_s(lk_to_s),
        .asm_req(asm_req), .asm_shift_mode(asm_shift_mode), .asm_off(asm_off),
        .asm_len(asm_len),
        .d_q(d_q), .s_q(s_q), .lk_valid(lk_valid), .lk_err(lk_err)
    );

    always #10 clk = ~clk;  // 50 MHz

    int    n_checks = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    bit    started = 1'b0;
    string cur_tag = "R1";

    // Reference model state
    logic [31:0] m_mem [256];
    logic [31:0] m_d = '0, m_s = '0, p_val = '0;
    bit          m_valid = 1'b0, m_err = 1'b0;
    bit          p_vld = 1'b0, p_err = 1'b0, p_to_s = 1'b0;
    int          m_base = 0, m_bytes = 4;

    function automatic int entry_bytes(int src, int dst);
        if (dst < src) return 1;
        if (dst == src) return 4;
        if (src == 0) return (dst == 1) ? 2 : 4;
        if (src == 1) return (dst == 2) ? 2 : 4;
        return 2;
    endfunction

    function automatic logic [31:0] byte_mask(int b);
        if (b == 1) return 32'h0000_00FF;
        if (b == 2) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    always @(posedge clk) begin
        int o, n;
        logic [31:0] nxt_s, msk, idx;
        cyc++;
        if (rst) begin
            m_d = '0; m_s = '0; m_valid = 0; m_err = 0;
            p_vld = 0; p_err = 0; p_to_s = 0;
            m_base = 0; m_bytes = 4;
        end else begin
            m_valid = p_vld;
            m_err   = p_vld && p_err;
            nxt_s   = m_s;
            if (asm_req) begin
                o = int'(asm_off); n = int'(asm_len);
                if (asm_shift_mode) begin
                    if (o == 0) nxt_s = m_d;
                    else if (n >= 32) nxt_s = m_d;
                    else nxt_s = (m_s << n) | m_d;
                end else if (o + n <= 32) begin
                    if (o == 0) nxt_s = (n == 0) ? 32'h0 : (m_d << (32 - n));
                    else nxt_s = m_s | (m_d << (32 - o - n));
                end
            end
            if (p_vld) begin
                if (p_to_s) nxt_s = p_val;
                else m_d = p_val;
            end
            m_s = nxt_s;
            p_vld = lk_req;
            if (lk_req) begin
                o = int'(lk_off); n = int'(lk_len);
                p_to_s = lk_to_s;
                if (n == 0 || o + n > 32) begin
                    p_err = 1; p_val = '0;
                end else begin
                    p_err = 0;
                    msk = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
                    idx = (lk_word >> (32 - o - n)) & msk;
                    p_val = m_mem[(m_base + int'(idx[7:0])) & 255] & byte_mask(m_bytes);
                end
            end
            if (tab_we) m_mem[tab_addr] = tab_data;
            if (cfg_we) begin
                m_base  = int'(cfg_base);
                m_bytes = entry_bytes(int'(cfg_src_depth), int'(cfg_dst_depth));
            end
        end
        started = 1'b1;
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            n_checks++;
            if (d_q !== m_d || s_q !== m_s || lk_valid !== m_valid || lk_err !== m_err) begin
                n_fail++;
                $display("FAIL %s cyc %0d: d %h/%h s %h/%h valid %b/%b err %b/%b (actual/expected)",
                         cur_tag, cyc, d_q, m_d, s_q, m_s, lk_valid, m_valid, lk_err, m_err);
            end
        end
    end

    task automatic check_word(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic set_cfg(int src, int dst, int base);
        @(negedge clk);
        cfg_we = 1; cfg_src_depth = 2'(src); cfg_dst_depth = 2'(dst); cfg_base = 8'(base);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic lookup(logic [31:0] w, int o, int n, bit to_s);
        @(negedge clk);
        lk_req = 1; lk_word = w; lk_off = 6'(o); lk_len = 6'(n); lk_to_s = to_s;
        @(negedge clk);
        lk_req = 0;
        @(negedge clk);
    endtask

    task automatic pack(bit mode, int o, int n);
        @(negedge clk);
        asm_req = 1; asm_shift_mode = mode; asm_off = 6'(o); asm_len = 6'(n);
        @(negedge clk);
        asm_req = 0;
    endtask

    initial begin
        logic [31:0] placed_word;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 0;
        cur_tag = "R1";
        check_word("R1 d_q", d_q, 32'h0);
        check_word("R1 s_q", s_q, 32'h0);
        check_word("R1 flags", {30'h0, lk_valid, lk_err}, 32'h0);

        // Fill the table with full-width distinct patterns.
        cur_tag = "R2";
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            tab_we = 1; tab_addr = 8'(i); tab_data = 32'h9E37_79B9 * (i + 1) ^ 32'hF000_0000;
        end
        @(negedge clk);
        tab_we = 0;

        // R2: field extraction with offset from MSB, both destinations (R5)
        lookup(32'hA1B2_C3D4, 0, 8, 0);
        lookup(32'hA1B2_C3D4, 24, 8, 1);
        lookup(32'hA1B2_C3D4, 5, 3, 0);
        lookup(32'h8000_0001, 31, 1, 1);
        lookup(32'h1234_5678, 0, 32, 0);
        cur_tag = "R5";
        lookup(32'h0F0F_0F0F, 12, 6, 1);
        lookup(32'h0F0F_0F0F, 12, 6, 0);

        // R4: every depth pair, nonzero base with wraparound
        cur_tag = "R4";
        for (int s = 0; s < 4; s++)
            for (int d = 0; d < 4; d++) begin
                set_cfg(s, d, 200 + 3 * s + d);
                lookup(32'hFEDC_BA98, 4, 8, 0);
                lookup(32'h7654_3210, 20, 4, 1);
            end
        set_cfg(0, 0, 0);

        // R6: error cases
        cur_tag = "R6";
        lookup(32'hFFFF_FFFF, 0, 0, 0);
        lookup(32'hFFFF_FFFF, 30, 4, 1);
        lookup(32'hFFFF_FFFF, 32, 1, 0);
        lookup(32'hFFFF_FFFF, 1, 32, 1);

        // R3: back-to-back requests
        cur_tag = "R3";
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            lk_req = 1; lk_word = 32'h1111_1111 * (k + 1); lk_off = 6'(k * 4); lk_len = 6'd8;
            lk_to_s = k[0];
            @(negedge clk);
        end
        lk_req = 0;
        repeat (3) @(negedge clk);

        // R7: placed packing of four 8-bit fields from 1-byte entries
        set_cfg(3, 0, 0);
        cur_tag = "R7";
        for (int f = 0; f < 4; f++) begin
            lookup(32'h3C00_0000 + 32'(f * 37), 24, 8, 0);
            pack(0, f * 8, 8);
        end
        @(negedge clk);
        placed_word = s_q;

        // R8: same fields, shift-accumulate
        cur_tag = "R8";
        for (int f = 0; f < 4; f++) begin
            lookup(32'h3C00_0000 + 32'(f * 37), 24, 8, 0);
            pack(1, f * 8, 8);
        end
        @(negedge clk);
        check_word("R11 placed vs shift-accumulate", s_q, placed_word);

        // R9: out-of-range placed step leaves S unchanged
        cur_tag = "R9";
        held = s_q;
        pack(0, 20, 16);
        @(negedge clk);
        check_word("R9 S unchanged", s_q, held);
        pack(0, 0, 40);
        @(negedge clk);
        check_word("R9 S unchanged o=0", s_q, held);

        // R10: lookup write-back to S coincides with a packing step
        cur_tag = "R10";
        @(negedge clk);
        lk_req = 1; lk_word = 32'h0000_00AB; lk_off = 6'd24; lk_len = 6'd8; lk_to_s = 1;
        @(negedge clk);
        lk_req = 0; asm_req = 1; asm_shift_mode = 1; asm_off = 6'd8; asm_len = 6'd8;
        @(negedge clk);
        asm_req = 0;
        check_word("R10 lookup wins", s_q, m_mem[8'hAB] & 32'hFF);

        // R12: configuration write on the same edge as a lookup
        cur_tag = "R12";
        set_cfg(0, 0, 0);
        @(negedge clk);
        cfg_we = 1; cfg_src_depth = 2'd3; cfg_dst_depth = 2'd0; cfg_base = 8'd16;
        lk_req = 1; lk_word = 32'h0500_0000; lk_off = 6'd0; lk_len = 6'd8; lk_to_s = 0;
        @(negedge clk);
        cfg_we = 0; lk_req = 0;
        @(negedge clk);
        check_word("R12 old config used", d_q, m_mem[8'h05]);
        lookup(32'h0500_0000, 0, 8, 0);
        check_word("R12 new config used", d_q, m_mem[8'h15] & 32'hFF);

        // Random overlap of all inputs
        cur_tag = "R5";
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            tab_we = ($urandom % 8) == 0; tab_addr = 8'($urandom); tab_data = $urandom;
            cfg_we = ($urandom % 16) == 0; cfg_src_depth = 2'($urandom);
            cfg_dst_depth = 2'($urandom); cfg_base = 8'($urandom);
            lk_req = $urandom % 2; lk_word = $urandom; lk_off = 6'($urandom % 36);
            lk_len = 6'($urandom % 36); lk_to_s = $urandom % 2;
            asm_req = $urandom % 2; asm_shift_mode = $urandom % 2;
            asm_off = 6'($urandom % 36); asm_len = 6'($urandom % 36);
        end
        @(negedge clk);
        tab_we = 0; cfg_we = 0; lk_req = 0; asm_req = 0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule